// File: doc/BRIEF.md
# PCI Target Read Data-Phase Controller

This block runs the data phases of a PCI target read once the address phase has been claimed elsewhere. Read data waits in a local FIFO, and the block sees only that FIFO's empty and full flags. From those flags, two active-low local requests (a start hold and a burst-pending request) and the master's FRAME# and IRDY#, it drives the target's active-low TRDY# and STOP#. It also issues one FIFO pop for each completed data phase.

After a claim, the first data phase is held back while the local hold request is asserted. It starts when the hold is released or the FIFO reports full. Later, if the FIFO runs dry between data phases, the burst-pending request selects what happens. When it is asserted, the target waits a bounded number of cycles for more data. When it is released, the target disconnects at once. Everything runs on the PCI clock with a synchronous active-low reset.

Top module: `pci_trd_phase_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `trdy_n` and `stop_n` high and `fifo_pop` low, the controller is idle and the wait count is zero.
- R2: After `rd_claim` is sampled high in idle, `trdy_n` stays high in every cycle in which `hold_n` is low and `fifo_full` is low.
- R3: The first data phase is offered (`trdy_n` low) in the cycle after the first edge at which `hold_n` is high or `fifo_full` is high, whichever comes first.
- R4: `trdy_n` is never low while `fifo_empty` is high, and `trdy_n` and `stop_n` are never low together.
- R5: A data phase completes only when `trdy_n` and `irdy_n` are both low. In that cycle only, `fifo_pop` is high and the wait count is cleared.
- R6: With `bpend_n` low, a FIFO that stays empty after a data phase gives exactly MAX_WAIT (default 8) wait cycles with both `trdy_n` and `stop_n` high. In the cycle after those, `stop_n` goes low.
- R7: If the FIFO becomes non-empty within the wait window (at the latest in its last cycle), `trdy_n` goes low in that same cycle and no disconnect occurs. The next completed phase restarts the full window.
- R8: With `bpend_n` high, `stop_n` goes low (with `trdy_n` high) in the first cycle that an active transfer sees `fifo_empty` high, with no wait cycles.
- R9: Once `stop_n` is low it stays low until an edge samples `frame_n` high. In the next cycle both `trdy_n` and `stop_n` are high and the controller is idle.
- R10: A data phase that completes with `frame_n` high ends the transaction without STOP#. The next cycle has `trdy_n` and `stop_n` high and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_claim | input | 1 | One-cycle pulse: a read has been claimed |
| frame_n | input | 1 | Master FRAME#, active low |
| irdy_n | input | 1 | Master IRDY#, active low |
| fifo_empty | input | 1 | Read-data FIFO holds no word |
| fifo_full | input | 1 | Read-data FIFO is full |
| hold_n | input | 1 | Local start hold, active low, held at least two cycles |
| bpend_n | input | 1 | Local burst-pending request, active low, held at least two cycles |
| trdy_n | output | 1 | Target TRDY#, active low |
| stop_n | output | 1 | Target STOP#, active low |
| fifo_pop | output | 1 | Remove one word from the FIFO at this edge |

## Verification
The assertions check the per-cycle safety rules on every cycle: TRDY# never offered over an empty FIFO, TRDY# and STOP# never together, a pop only on a completed phase, STOP# held until FRAME# rises, a return to idle after a final phase, and the wait count bounded and free of any early disconnect inside the window. Only the bench's scenarios show the exact counts and orderings. These are the precise number of wait cycles before STOP#, the difference between data arriving in the last window cycle and one cycle later, the race between hold release and FIFO full, and the window restarting after a late phase completes.

// File: rtl/pci_trd_pkg.sv
package pci_trd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_DISC   = 2'd3
  } trd_state_e;

  // First data phase may begin once the local hold is released or the FIFO is full
  function automatic logic start_allowed(input logic hold_req_n, input logic full);
    return hold_req_n | full;
  endfunction

  // Wait budget is used up once the count has reached the limit
  function automatic logic budget_spent(input int unsigned count, input int unsigned limit);
    return count >= limit;
  endfunction

endpackage

// File: rtl/pci_trd_wait_ctr.sv
module pci_trd_wait_ctr #(
  parameter int unsigned MAX_WAIT = 8,
  localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             spent
);
  import pci_trd_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (inc && (cnt < LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign spent = budget_spent(int'(cnt), MAX_WAIT);

endmodule

// File: rtl/pci_trd_seq.sv
module pci_trd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_claim,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic fifo_empty,
  input  logic fifo_full,
  input  logic hold_n,
  input  logic bpend_n,
  input  logic spent,
  output logic trdy_n,
  output logic stop_n,
  output logic fifo_pop,
  output logic phase_done,
  output logic wait_inc,
  output logic wait_clr,
  output logic in_hold,
  output logic in_active
);
  import pci_trd_pkg::*;

  trd_state_e state, state_nxt;
  logic in_disc, data_rdy, dry, give_up;

  assign in_hold   = (state == ST_HOLD);
  assign in_active = (state == ST_ACTIVE);
  assign in_disc   = (state == ST_DISC);

  assign data_rdy   = in_active & ~fifo_empty;
  assign dry        = in_active & fifo_empty;
  assign give_up    = dry & (bpend_n | spent);
  assign phase_done = data_rdy & ~irdy_n;

  assign trdy_n   = ~data_rdy;
  assign stop_n   = ~(give_up | in_disc);
  assign fifo_pop = phase_done;
  assign wait_inc = dry & ~give_up;
  assign wait_clr = phase_done | ~in_active;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:   if (rd_claim) state_nxt = ST_HOLD;
      ST_HOLD:   if (start_allowed(hold_n, fifo_full)) state_nxt = ST_ACTIVE;
      ST_ACTIVE: begin
        if (phase_done && frame_n)  state_nxt = ST_IDLE;
        else if (give_up)           state_nxt = frame_n ? ST_IDLE : ST_DISC;
      end
      ST_DISC:   if (frame_n) state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

endmodule

// File: rtl/pci_trd_phase_ctl.sv
module pci_trd_phase_ctl #(
  parameter int unsigned MAX_WAIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_claim,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic fifo_empty,
  input  logic fifo_full,
  input  logic hold_n,
  input  logic bpend_n,
  output logic trdy_n,
  output logic stop_n,
  output logic fifo_pop
);
  localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1);

  logic             phase_done;
  logic             wait_inc;
  logic             wait_clr;
  logic             wait_spent;
  logic             in_hold;
  logic             in_active;
  logic [CNT_W-1:0] wait_cnt;

  pci_trd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_claim   (rd_claim),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .hold_n     (hold_n),
    .bpend_n    (bpend_n),
    .spent      (wait_spent),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .fifo_pop   (fifo_pop),
    .phase_done (phase_done),
    .wait_inc   (wait_inc),
    .wait_clr   (wait_clr),
    .in_hold    (in_hold),
    .in_active  (in_active)
  );

  pci_trd_wait_ctr #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wait_clr),
    .inc   (wait_inc),
    .cnt   (wait_cnt),
    .spent (wait_spent)
  );

endmodule

// File: rtl/pci_trd_phase_chk.sv
module pci_trd_phase_chk #(
  parameter int unsigned MAX_WAIT = 8,
  localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_n,
  input logic             irdy_n,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic             hold_n,
  input logic             bpend_n,
  input logic             trdy_n,
  input logic             stop_n,
  input logic             fifo_pop,
  input logic             in_hold,
  input logic             in_active,
  input logic [CNT_W-1:0] wait_cnt
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WAIT);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (trdy_n && stop_n && !fifo_pop && !in_active && wait_cnt == '0));

  // R2
  hold_blocks_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !hold_n && !fifo_full) |-> trdy_n);

  // R3
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && (hold_n || fifo_full)) |=> in_active);

  // R4
  no_trdy_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> (!fifo_empty && stop_n));

  // R5
  pop_on_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (!trdy_n && !irdy_n));

  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= LIMIT);

  // R7
  no_early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_active && fifo_empty && !bpend_n && wait_cnt < LIMIT) |-> (stop_n ##1 in_active));

  // R8
  immediate_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_active && fifo_empty && bpend_n) |-> (!stop_n && trdy_n));

  // R9
  stop_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> !stop_n);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && frame_n) |=> (stop_n && trdy_n && !in_active));

  // R10
  last_phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && frame_n) |=> (trdy_n && stop_n && !in_active));

endmodule

bind pci_trd_phase_ctl pci_trd_phase_chk #(.MAX_WAIT(MAX_WAIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .hold_n     (hold_n),
  .bpend_n    (bpend_n),
  .trdy_n     (trdy_n),
  .stop_n     (stop_n),
  .fifo_pop   (fifo_pop),
  .in_hold    (in_hold),
  .in_active  (in_active),
  .wait_cnt   (wait_cnt)
);

// File: tb/test_pci_trd_phase_ctl.sv
module test_pci_trd_phase_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_claim = 1'b0;
  logic frame_n = 1'b1;
  logic irdy_n = 1'b1;
  logic fifo_empty = 1'b1;
  logic fifo_full = 1'b0;
  logic hold_n = 1'b1;
  logic bpend_n = 1'b1;
  logic trdy_n, stop_n, fifo_pop;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_trd_phase_ctl #(.MAX_WAIT(MAXW)) i_pci_trd_phase_ctl (
    .clk(clk), .rst_n(rst_n), .rd_claim(rd_claim), .frame_n(frame_n),
    .irdy_n(irdy_n), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .hold_n(hold_n), .bpend_n(bpend_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .fifo_pop(fifo_pop)
  );

  // Inputs change just after the falling edge; outputs are sampled 1 time unit later
  task automatic drive(input logic c, input logic fr, input logic ir, input logic em,
                       input logic fu, input logic ho, input logic bp);
    @(negedge clk);
    rd_claim = c; frame_n = fr; irdy_n = ir; fifo_empty = em;
    fifo_full = fu; hold_n = ho; bpend_n = bp;
    #1;
  endtask

  task automatic expect3(input string req, input logic et, input logic es, input logic ep);
    checks++;
    if (trdy_n !== et || stop_n !== es || fifo_pop !== ep) begin
      errors++;
      $display("FAIL %s: trdy_n/stop_n/pop actual %b%b%b expected %b%b%b at %0t",
               req, trdy_n, stop_n, fifo_pop, et, es, ep, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(0, 1, 1, 1, 0, 1, 1);
    drive(0, 1, 1, 0, 0, 1, 1);
    expect3("R1", 1, 1, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // hold released before the FIFO fills
  task automatic t_hold_release();
    drive(1, 0, 0, 0, 0, 0, 0);
    expect3("R2", 1, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 0); expect3("R2", 1, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 0); expect3("R2", 1, 1, 0);
    drive(0, 0, 0, 0, 0, 1, 0); expect3("R3", 1, 1, 0);
    drive(0, 0, 0, 0, 0, 1, 0); expect3("R3", 0, 1, 1);
    drive(0, 1, 0, 0, 0, 1, 0); expect3("R5", 0, 1, 1);
    drive(0, 1, 1, 0, 0, 1, 1); expect3("R10", 1, 1, 0);
  endtask

  // FIFO fills while hold is still asserted
  task automatic t_full_first();
    drive(1, 0, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0); expect3("R2", 1, 1, 0);
    drive(0, 0, 1, 0, 1, 0, 0); expect3("R3", 1, 1, 0);
    drive(0, 0, 1, 0, 1, 0, 0); expect3("R3", 0, 1, 0);
    drive(0, 1, 0, 0, 1, 1, 0); expect3("R5", 0, 1, 1);
    drive(0, 1, 1, 0, 0, 1, 1); expect3("R10", 1, 1, 0);
  endtask

  // one data phase, then the FIFO stays empty with burst pending asserted
  task automatic t_wait_disc(input int dry_cycles);
    drive(1, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 1, 0); expect3("R5", 0, 1, 1);
    for (int i = 0; i < dry_cycles; i++) begin
      drive(0, 0, 0, 1, 0, 1, 0); expect3("R6", 1, 1, 0);
    end
  endtask

  task automatic t_eight_waits();
    t_wait_disc(MAXW);
    drive(0, 0, 0, 1, 0, 1, 0); expect3("R6", 1, 0, 0);
    drive(0, 0, 1, 0, 0, 1, 0); expect3("R9", 1, 0, 0);
    drive(0, 1, 1, 0, 0, 1, 0); expect3("R9", 1, 0, 0);
    drive(0, 1, 1, 0, 0, 1, 1); expect3("R9", 1, 1, 0);
  endtask

  task automatic t_late_data();
    t_wait_disc(MAXW - 1);
    drive(0, 0, 0, 0, 0, 1, 0); expect3("R7", 0, 1, 1);
    for (int i = 0; i < MAXW; i++) begin
      drive(0, 0, 0, 1, 0, 1, 0); expect3("R7", 1, 1, 0);
    end
    drive(0, 1, 0, 1, 0, 1, 0); expect3("R7", 1, 0, 0);
    drive(0, 1, 1, 1, 0, 1, 1); expect3("R9", 1, 1, 0);
  endtask

  task automatic t_no_burst();
    drive(1, 0, 0, 0, 0, 1, 1);
    drive(0, 0, 0, 0, 0, 1, 1);
    drive(0, 0, 0, 0, 0, 1, 1); expect3("R5", 0, 1, 1);
    drive(0, 0, 0, 1, 0, 1, 1); expect3("R8", 1, 0, 0);
    drive(0, 0, 1, 0, 0, 1, 1); expect3("R9", 1, 0, 0);
    drive(0, 1, 1, 0, 0, 1, 1); expect3("R9", 1, 0, 0);
    drive(0, 1, 1, 0, 0, 1, 1); expect3("R9", 1, 1, 0);
  endtask

  // master inserts IRDY# waits: no pop and no wait counting while data is present
  task automatic t_master_waits();
    drive(1, 0, 1, 0, 0, 1, 0);
    drive(0, 0, 1, 0, 0, 1, 0);
    for (int i = 0; i < MAXW + 2; i++) begin
      drive(0, 0, 1, 0, 0, 1, 0); expect3("R5", 0, 1, 0);
    end
    drive(0, 1, 0, 0, 0, 1, 0); expect3("R10", 0, 1, 1);
    drive(0, 1, 1, 0, 0, 1, 1); expect3("R10", 1, 1, 0);
  endtask

  initial begin
    t_reset();
    t_hold_release();
    t_full_first();
    t_eight_waits();
    t_late_data();
    t_no_burst();
    t_master_waits();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule